// File: doc/BRIEF.md
# OUT Endpoint Buffer and Handshake Controller

This block holds the control and status state of one receive (host-to-device) USB endpoint whose packet memory holds two data sets. The device controller sends it one-cycle event pulses. These mark the start of an OUT token, a packet received without error together with its data PID, a packet that failed its CRC or bit-stuff check, and a packet longer than the endpoint's maximum size. One cycle later the block returns the handshake to send (ACK, NAK or STALL) and a pulse that tells the packet memory to keep the data just received. Packet storage, the serial engine and CRC logic sit outside this block.

On the processor side, a register port reads back the occupancy and three sticky error flags. Command bits are written as ones: unload one data set, flush one data set, clear each error flag, and restart the data toggle. The block can be placed once for each endpoint. An input selects whether the endpoint runs isochronous transfers, which get no handshake and no toggle check, or handshaked transfers.

Top module: `out_ep_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0: empty buffer, all flags clear, and DATA0 expected. Occupancy reads on bits [1:0] as 00 for empty, 10 for one data set and 11 for two. The value 01 never appears.
- R2: The cycle after a packet is kept, `store` pulses and occupancy rises by one. While two data sets are held, no packet is kept.
- R3: Writing 1 to bit 5 (unload) removes one data set when at least one is held. When the buffer is empty, the write has no effect on occupancy.
- R4: Writing 1 to bit 10 (flush) empties a buffer holding one data set, and leaves one data set when two are held. When the buffer is empty, the write has no effect. If bits 5 and 10 are written together, only one data set is removed.
- R5: On an isochronous endpoint, a token arriving while two data sets are held sets the overrun flag (bit 2). Writing 1 to bit 6 clears it.
- R6: An oversize packet sets the stall flag (bit 3). The next cycle brings `hs_valid` with `hs_code` = 2'b10 (STALL), and nothing is stored. Writing 1 to bit 7 clears the flag.
- R7: A CRC or bit-stuff error on an isochronous endpoint sets the data-error flag (bit 4). Writing 1 to bit 8 clears it. On a handshaked endpoint the error sets no flag and gives no handshake.
- R8: On a handshaked endpoint with room, a packet whose PID (`rx_pid`, 0 = DATA0) matches the expected toggle gets ACK (`hs_code` = 2'b00), is stored, and flips the toggle. A packet with a mismatched PID gets ACK but is neither stored nor counted, and the toggle stays as it was.
- R9: On a handshaked endpoint, a packet gets NAK (`hs_code` = 2'b01) and is not stored in either of two cases: two data sets were held at its token, or two are held when it arrives.
- R10: Writing 1 to bit 9 makes the next expected PID DATA0. This write takes precedence over a toggle flip in the same cycle.
- R11: On an isochronous endpoint, a good packet gets no handshake and is stored whenever fewer than two data sets are held, whatever its PID.
- R12: Bits 5 and above of `reg_rdata` always read 0. A flag set by an event in the same cycle as its clear write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_iso | input | 1 | 1 = isochronous endpoint |
| tok_start | input | 1 | Pulse at the start of an OUT token |
| rx_done | input | 1 | Pulse: packet received without error |
| rx_pid | input | 1 | Data PID of the received packet, 0 = DATA0, 1 = DATA1 |
| rx_err | input | 1 | Pulse: CRC or bit-stuff error |
| rx_oversize | input | 1 | Pulse: packet exceeded maximum size |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Write-one command bits |
| reg_rdata | output | DATA_W | Occupancy and sticky flags |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| store | output | 1 | Keep the packet just received |

## Verification
Directed sequences drive packets with matching PIDs, mismatched PIDs and alternating PIDs. These separate toggle-driven acceptance from acceptance by occupancy, and show that a restarted toggle takes effect on the next packet. Tokens and packets arrive at every occupancy level, in both endpoint types. This separates a NAK latched at the token from one decided when the data arrives, and separates the isochronous overrun from the handshaked refusal. A pseudo-random sweep then mixes events with command writes in the same cycle. An arithmetic model of count, toggle and flags checks the ordering cases: unload against a store, clear against a set, and restart against a flip.

// File: rtl/oep_pkg.sv
`timescale 1ns/1ps
package oep_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_code_e;

    // read-side field positions
    localparam int unsigned RD_FULL     = 0;
    localparam int unsigned RD_NONEMPTY = 1;
    localparam int unsigned RD_FLAG_LO  = 2;

    // write-one command positions
    localparam int unsigned WR_UNLOAD    = 5;
    localparam int unsigned WR_CLR_LO    = 6;
    localparam int unsigned WR_TOG_INIT  = 9;
    localparam int unsigned WR_FLUSH     = 10;
    localparam int unsigned CMD_TOP      = 10;

    // sticky flag indices
    localparam int unsigned NUM_FLAGS  = 3;
    localparam int unsigned FLAG_OVR   = 0;
    localparam int unsigned FLAG_STALL = 1;
    localparam int unsigned FLAG_DERR  = 2;

    typedef struct packed {
        logic     nak_pend;
        logic     hs_valid;
        hs_code_e hs_code;
        logic     store;
    } ctl_state_t;

endpackage

// File: rtl/oep_fill.sv
`timescale 1ns/1ps
module oep_fill #(
    parameter int unsigned MAX_SETS = 2,
    localparam int unsigned CNT_W = $clog2(MAX_SETS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_req,
    input  logic dec_req,
    output logic full,
    output logic nonempty
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             do_inc, do_dec;

    always_comb begin
        do_inc = inc_req && (cnt_q != CNT_W'(MAX_SETS));
        do_dec = dec_req && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (do_inc && !do_dec) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else if (!do_inc && do_dec) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign full     = (cnt_q == CNT_W'(MAX_SETS));
    assign nonempty = (cnt_q != '0);

endmodule

// File: rtl/oep_sticky.sv
`timescale 1ns/1ps
module oep_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) begin
            flag_d = 1'b0;
        end
        if (set) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/oep_seq.sv
`timescale 1ns/1ps
module oep_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic restart,
    output logic expect_pid
);

    logic pid_d, pid_q;

    always_comb begin
        pid_d = pid_q;
        if (advance) begin
            pid_d = ~pid_q;
        end
        if (restart) begin
            pid_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= 1'b0;
        end else begin
            pid_q <= pid_d;
        end
    end

    assign expect_pid = pid_q;

endmodule

// File: rtl/out_ep_ctrl.sv
`timescale 1ns/1ps
module out_ep_ctrl
    import oep_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_iso,
    input  logic              tok_start,
    input  logic              rx_done,
    input  logic              rx_pid,
    input  logic              rx_err,
    input  logic              rx_oversize,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              store
);

    // two data sets: the two-bit occupancy code depends on it
    localparam int unsigned NUM_SETS = 2;

    ctl_state_t st_d, st_q;

    logic full, nonempty, expect_pid;
    logic inc_req, dec_req, advance, restart;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic unused_wbits;

    // ---------------- command decode ----------------
    always_comb begin
        dec_req = reg_wr && (reg_wdata[WR_UNLOAD] || reg_wdata[WR_FLUSH]);
        restart = reg_wr && reg_wdata[WR_TOG_INIT];
        for (int i = 0; i < int'(NUM_FLAGS); i++) begin
            flag_clr[i] = reg_wr && reg_wdata[WR_CLR_LO + i];
        end
    end

    assign unused_wbits = ^{reg_wdata[WR_UNLOAD-1:0], reg_wdata[DATA_W-1:CMD_TOP+1]};

    // ---------------- event decision ----------------
    always_comb begin
        st_d          = st_q;
        st_d.hs_valid = 1'b0;
        st_d.hs_code  = HS_ACK;
        st_d.store    = 1'b0;
        inc_req       = 1'b0;
        advance       = 1'b0;
        flag_set      = '0;

        if (rx_oversize) begin
            st_d.hs_valid         = 1'b1;
            st_d.hs_code          = HS_STALL;
            flag_set[FLAG_STALL]  = 1'b1;
            st_d.nak_pend         = 1'b0;
        end else if (rx_err) begin
            flag_set[FLAG_DERR]   = cfg_iso;
            st_d.nak_pend         = 1'b0;
        end else if (rx_done) begin
            if (cfg_iso) begin
                inc_req    = !full;
                st_d.store = !full;
            end else if (st_q.nak_pend || full) begin
                st_d.hs_valid = 1'b1;
                st_d.hs_code  = HS_NAK;
            end else begin
                st_d.hs_valid = 1'b1;
                st_d.hs_code  = HS_ACK;
                if (rx_pid == expect_pid) begin
                    inc_req    = 1'b1;
                    st_d.store = 1'b1;
                    advance    = 1'b1;
                end
            end
            st_d.nak_pend = 1'b0;
        end

        if (tok_start) begin
            if (cfg_iso) begin
                flag_set[FLAG_OVR] = full;
                st_d.nak_pend      = 1'b0;
            end else begin
                st_d.nak_pend      = full;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{nak_pend: 1'b0, hs_valid: 1'b0, hs_code: HS_ACK, store: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- state holders ----------------
    oep_fill #(.MAX_SETS(NUM_SETS)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_req  (inc_req),
        .dec_req  (dec_req),
        .full     (full),
        .nonempty (nonempty)
    );

    oep_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .restart    (restart),
        .expect_pid (expect_pid)
    );

    for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_flag
        oep_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .flag  (flag_q[g])
        );
    end

    // ---------------- outputs ----------------
    always_comb begin
        reg_rdata                                 = '0;
        reg_rdata[RD_FULL]                        = full;
        reg_rdata[RD_NONEMPTY]                    = nonempty;
        reg_rdata[RD_FLAG_LO +: NUM_FLAGS]        = flag_q;
    end

    assign hs_valid = st_q.hs_valid;
    assign hs_code  = st_q.hs_code;
    assign store    = st_q.store;

endmodule

// File: rtl/oep_checker.sv
`timescale 1ns/1ps
module oep_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_iso,
    input logic              tok_start,
    input logic              rx_done,
    input logic              rx_err,
    input logic              rx_oversize,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              hs_valid,
    input logic [1:0]        hs_code,
    input logic              store
);

    AST_STS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1:0] != 2'b01); // R1

    AST_FULL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && reg_rdata[0]) |=> !store); // R2

    AST_ISO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_iso && tok_start && reg_rdata[0]) |=> reg_rdata[2]); // R5

    AST_STALL_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_oversize |=> (hs_valid && hs_code == 2'b10 && !store && reg_rdata[3])); // R6

    AST_ISO_NO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_iso && rx_done && !rx_err && !rx_oversize) |=> !hs_valid); // R11

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:5] == '0); // R12

endmodule

bind out_ep_ctrl oep_checker #(.DATA_W(DATA_W)) u_oep_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_iso     (cfg_iso),
    .tok_start   (tok_start),
    .rx_done     (rx_done),
    .rx_err      (rx_err),
    .rx_oversize (rx_oversize),
    .reg_rdata   (reg_rdata),
    .hs_valid    (hs_valid),
    .hs_code     (hs_code),
    .store       (store)
);

// File: tb/test_out_ep_ctrl.sv
`timescale 1ns/1ps
module test_out_ep_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_iso = 1'b0;
    logic        tok_start = 1'b0;
    logic        rx_done = 1'b0;
    logic        rx_pid = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_oversize = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        store;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int m_cnt = 0;
    bit m_tog = 0, m_ovr = 0, m_stall = 0, m_derr = 0, m_nakp = 0;

    always #5 clk = ~clk;

    out_ep_ctrl #(.DATA_W(16)) i_out_ep_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_iso     (cfg_iso),
        .tok_start   (tok_start),
        .rx_done     (rx_done),
        .rx_pid      (rx_pid),
        .rx_err      (rx_err),
        .rx_oversize (rx_oversize),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .hs_valid    (hs_valid),
        .hs_code     (hs_code),
        .store       (store)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rdata();
        return ((m_cnt > 0) ? 2 : 0) + ((m_cnt == 2) ? 1 : 0)
             + (int'(m_ovr) << 2) + (int'(m_stall) << 3) + (int'(m_derr) << 4);
    endfunction

    // one event cycle, optionally with a register write in the same cycle
    task automatic step(input string tag, input bit tok, input bit done, input bit pid,
                        input bit err, input bit ovs, input bit wr, input logic [15:0] wd);
        bit ehv = 0, est = 0, inc = 0, adv = 0, dec;
        int ehc = 0;
        bit s_ovr = 0, s_stall = 0, s_derr = 0;
        bit full = (m_cnt == 2);
        bit nakp_n = m_nakp;
        @(negedge clk);
        tok_start = tok; rx_done = done; rx_pid = pid; rx_err = err;
        rx_oversize = ovs; reg_wr = wr; reg_wdata = wd;
        if (ovs) begin
            ehv = 1; ehc = 2; s_stall = 1; nakp_n = 0;
        end else if (err) begin
            s_derr = cfg_iso; nakp_n = 0;
        end else if (done) begin
            if (cfg_iso) begin
                est = !full; inc = !full;
            end else if (m_nakp || full) begin
                ehv = 1; ehc = 1;
            end else begin
                ehv = 1; ehc = 0;
                if (pid == m_tog) begin est = 1; inc = 1; adv = 1; end
            end
            nakp_n = 0;
        end
        if (tok) begin
            if (cfg_iso) begin s_ovr = full; nakp_n = 0; end
            else nakp_n = full;
        end
        dec = wr && (wd[5] || wd[10]) && (m_cnt != 0);
        m_cnt = m_cnt + int'(inc) - int'(dec);
        if (wr && wd[6]) m_ovr = 0;
        if (wr && wd[7]) m_stall = 0;
        if (wr && wd[8]) m_derr = 0;
        if (s_ovr) m_ovr = 1;
        if (s_stall) m_stall = 1;
        if (s_derr) m_derr = 1;
        if (adv) m_tog = ~m_tog;
        if (wr && wd[9]) m_tog = 0;
        m_nakp = nakp_n;
        @(negedge clk);
        tok_start = 0; rx_done = 0; rx_err = 0; rx_oversize = 0; reg_wr = 0; reg_wdata = '0;
        chk({tag, " hs_valid"}, int'(hs_valid), int'(ehv));
        if (ehv) chk({tag, " hs_code"}, int'(hs_code), ehc);
        chk({tag, " store"}, int'(store), int'(est));
        chk({tag, " rdata"}, int'(reg_rdata), exp_rdata());
    endtask

    function automatic logic [15:0] lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset rdata", int'(reg_rdata), 0);
        chk("R1 reset hs_valid", int'(hs_valid), 0);
        chk("R1 reset store", int'(store), 0);
        rst_n = 1'b1;

        // handshaked endpoint
        cfg_iso = 1'b0;
        step("R8 match DATA0", 1, 0, 0, 0, 0, 0, '0);
        step("R8 match DATA0", 0, 1, 0, 0, 0, 0, '0);
        step("R8 mismatch repeat", 0, 1, 0, 0, 0, 0, '0);
        step("R2 second set", 0, 1, 1, 0, 0, 0, '0);
        chk("R2 two held", int'(reg_rdata[1:0]), 3);
        step("R9 token while full", 1, 0, 0, 0, 0, 0, '0);
        step("R9 nak data", 0, 1, 0, 0, 0, 0, '0);
        step("R9 full no token", 0, 1, 0, 0, 0, 0, '0);
        step("R12 all cmds readback", 0, 0, 0, 0, 0, 1, 16'hF81F);
        chk("R12 high bits", int'(reg_rdata[15:5]), 0);
        step("R3 unload", 0, 0, 0, 0, 0, 1, 16'h0020);
        chk("R3 one left", int'(reg_rdata[1:0]), 2);
        step("R4 flush last", 0, 0, 0, 0, 0, 1, 16'h0400);
        chk("R4 empty", int'(reg_rdata[1:0]), 0);
        step("R3 unload empty", 0, 0, 0, 0, 0, 1, 16'h0020);
        step("R4 flush empty", 0, 0, 0, 0, 0, 1, 16'h0400);
        step("R10 fill DATA0", 0, 1, 0, 0, 0, 0, '0);
        step("R10 fill DATA1", 0, 1, 1, 0, 0, 0, '0);
        step("R4 flush older of two", 0, 0, 0, 0, 0, 1, 16'h0400);
        chk("R4 one left", int'(reg_rdata[1:0]), 2);
        step("R4 both cmds one removed", 0, 1, 0, 0, 0, 1, 16'h0420);
        step("R10 restart toggle", 0, 0, 0, 0, 0, 1, 16'h0200);
        step("R10 DATA0 accepted", 0, 1, 0, 0, 0, 0, '0);
        step("R10 restart beats flip", 0, 1, 1, 0, 0, 1, 16'h0200);
        step("R10 DATA0 again", 0, 0, 0, 0, 0, 1, 16'h0420);
        step("R6 oversize", 0, 0, 0, 0, 1, 0, '0);
        step("R12 set beats clear", 0, 0, 0, 0, 1, 1, 16'h0080);
        step("R6 clear stall", 0, 0, 0, 0, 0, 1, 16'h0080);
        step("R7 error handshaked", 0, 0, 0, 1, 0, 0, '0);

        // isochronous endpoint
        step("R4 empty for iso", 0, 0, 0, 0, 0, 1, 16'h0420);
        step("R4 empty for iso", 0, 0, 0, 0, 0, 1, 16'h0420);
        cfg_iso = 1'b1;
        step("R11 iso DATA1", 1, 0, 0, 0, 0, 0, '0);
        step("R11 iso DATA1", 0, 1, 1, 0, 0, 0, '0);
        step("R11 iso DATA1 again", 0, 1, 1, 0, 0, 0, '0);
        step("R5 iso token full", 1, 0, 0, 0, 0, 0, '0);
        chk("R5 overrun flag", int'(reg_rdata[2]), 1);
        step("R2 iso full drop", 0, 1, 0, 0, 0, 0, '0);
        step("R5 clear overrun", 0, 0, 0, 0, 0, 1, 16'h0040);
        step("R7 iso error", 0, 0, 0, 1, 0, 0, '0);
        chk("R7 data error flag", int'(reg_rdata[4]), 1);
        step("R7 clear data error", 0, 0, 0, 0, 0, 1, 16'h0100);

        // pseudo-random sweep in both endpoint types
        for (int k = 0; k < 2; k++) begin
            cfg_iso = k[0];
            for (int i = 0; i < 1500; i++) begin
                logic [15:0] w;
                bit wr;
                int op;
                r = lfsr(r);
                w = lfsr(r);
                op = int'(r[2:0]) % 6;
                wr = (r[6:4] == 3'd0) || (r[6:4] == 3'd5);
                case (op)
                    0: step("R5 R9 sweep token", 1, 0, 0, 0, 0, wr, w);
                    1: step("R2 R8 R11 sweep data0", 0, 1, 0, 0, 0, wr, w);
                    2: step("R2 R8 R11 sweep data1", 0, 1, 1, 0, 0, wr, w);
                    3: step("R7 sweep error", 0, 0, 0, 1, 0, wr, w);
                    4: step("R6 sweep oversize", 0, 0, 0, 0, r[9] & r[11], wr, w);
                    default: step("R3 R4 R10 sweep write", 0, 0, 0, 0, 0, wr, w);
                endcase
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule